// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the periodic frequency-offset word that a fractional-N synthesizer adds to its nominal fractional divide word. Adding the offset makes the output clock sweep in frequency, which lowers the spectral peaks that cause EMI. An external modulation-rate tick advances the sweep one step at a time. A full modulation period is four quarters of 32 steps, 128 ticks in all.

Three settings shape the sweep. A mode select chooses a sweep that is symmetric about the nominal frequency (center) or one that stays at or below it (down). A profile select chooses a triangular sweep or a shaped sweep that lingers near the extremes. A depth code sets the excursion in units of roughly 0.125 % of the nominal word. The nominal word, the depth, the mode, the profile and the on/off control are all taken up only at a point where the offset is zero, so the synthesized frequency never jumps. When spreading is off the offset is zero. One instance serves each synthesizer that spreads; a synthesizer that does not spread has no instance.

Top module: `ssc_profile_gen`

## Requirements
- R1: After reset, offset_o is 0, cycle_start_o is 0 and spreading is off until a tick takes up spread_en_i = 1. Without a tick, offset_o stays 0.
- R2: While spreading is active, each tick advances the sweep step p (0..127) by one, and 127 wraps to 0. cycle_start_o is high for exactly one cycle after the tick that puts the block at step 0 with spreading on. This happens both on a wrap and when spreading is switched on. Consecutive pulses are 128 ticks apart, and offset_o is 0 at each pulse.
- R3: The excursion is span = floor(N·D·41943 / 2^25), where N is the taken-up nominal_i and D is the taken-up depth_i. A depth_i above 40 is taken as 40, and depth_i = 0 gives span 0.
- R4: With down_mode_i = 0 (center), offset_o = floor(w·span/32). Its extremes are +span at step 32 and -span at step 96, and it is 0 at steps 0 and 64.
- R5: With down_mode_i = 1 (down), offset_o = floor((w−32)·span/64). It is 0 at step 0, reaches -span at step 64, and is never positive.
- R6: The shape value w is defined as follows. Take the quarter q = p/32 and the index i = p%32. Set e = q in center mode and e = (q+1)%4 in down mode. Set j = i when e is even and j = 32−i when e is odd. Set w = +f(j) for e < 2 and w = −f(j) for e ≥ 2. With shaped_i = 0, f(j) = j. With shaped_i = 1, f(j) = floor(j·(64−j)/32).
- R7: While the taken-up spread_en_i is 0, offset_o is 0, the step is held at 0 and every tick takes up all inputs at once.
- R8: While spreading is active, a change of spread_en_i, down_mode_i, shaped_i, depth_i or nominal_i has no effect on offset_o until the tick that wraps the step from 127 to 0. That tick takes up the values present at that moment.
- R9: offset_o changes only in the cycle after a cycle in which tick_i was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Modulation-rate step strobe, one clock wide |
| spread_en_i | input | 1 | 1 turns spreading on |
| down_mode_i | input | 1 | 0 = center sweep, 1 = down sweep |
| shaped_i | input | 1 | 0 = triangular profile, 1 = shaped profile |
| depth_i | input | DEPTH_W (6) | Excursion in 0.125 % steps, 0..40 |
| nominal_i | input | FRAC_W (24) | Nominal fractional word that the offset is scaled from |
| offset_o | output | FRAC_W+1 (25) | Signed offset to add to the nominal word |
| cycle_start_o | output | 1 | One-cycle pulse at the start of each modulation period |

## Verification
The hardest case to reach is a settings change that arrives while a period is running. The change must be held back for up to 127 ticks and then take effect exactly on the wrapping tick, and it may arrive in a cycle without a tick or just before the wrap itself. A directed sequence changes depth and mode a few steps into a period and switches spreading off halfway through. Long random runs then change single inputs at random moments, with tick densities from sparse to every cycle. A bench model of the step and the take-up rule predicts every output cycle by cycle. Full-period sweeps in each mode and profile also check the observed maximum and minimum against the expected span.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

   // scale denominator: one depth unit is nominal / 800 (0.125 %)
   localparam int unsigned DEPTH_DEN = 800;

   // shaped quarter profile: rises fast, flattens toward the peak amp
   function automatic int unsigned shape_val(input int unsigned j, input int unsigned amp);
      return (j * (2 * amp - j)) / amp;
   endfunction

endpackage

// File: rtl/ssc_phase.sv
module ssc_phase #(
   parameter int unsigned QTR_LOG2  = 5,
   parameter int unsigned FRAC_W    = 24,
   parameter int unsigned DEPTH_W   = 6,
   parameter int unsigned DEPTH_MAX = 40
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  tick_i,
   input  logic                  en_i,
   input  logic                  down_i,
   input  logic                  shaped_i,
   input  logic [DEPTH_W-1:0]    depth_i,
   input  logic [FRAC_W-1:0]     nom_i,
   output logic [QTR_LOG2+1:0]   phase_o,
   output logic                  act_en_o,
   output logic                  act_down_o,
   output logic                  act_shaped_o,
   output logic [DEPTH_W-1:0]    act_depth_o,
   output logic [FRAC_W-1:0]     act_nom_o,
   output logic                  start_o
);
   localparam int unsigned          PH_W      = QTR_LOG2 + 2;
   localparam logic [PH_W-1:0]      PH_LAST   = {PH_W{1'b1}};
   localparam logic [DEPTH_W-1:0]   DEPTH_CAP = DEPTH_W'(DEPTH_MAX);

   logic                commit;
   logic [DEPTH_W-1:0]  depth_clip;

   always_comb begin
      // idle takes settings on any tick; active only on the wrapping tick
      commit     = tick_i && (!act_en_o || phase_o == PH_LAST);
      depth_clip = (depth_i > DEPTH_CAP) ? DEPTH_CAP : depth_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_o      <= '0;
         act_en_o     <= 1'b0;
         act_down_o   <= 1'b0;
         act_shaped_o <= 1'b0;
         act_depth_o  <= '0;
         act_nom_o    <= '0;
         start_o      <= 1'b0;
      end else begin
         start_o <= commit && en_i;
         if (commit) begin
            phase_o      <= '0;
            act_en_o     <= en_i;
            act_down_o   <= down_i;
            act_shaped_o <= shaped_i;
            act_depth_o  <= depth_clip;
            act_nom_o    <= nom_i;
         end else if (tick_i) begin
            phase_o <= phase_o + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ssc_wave.sv
module ssc_wave #(
   parameter int unsigned QTR_LOG2 = 5
) (
   input  logic [QTR_LOG2+1:0]        phase_i,
   input  logic                       down_i,
   input  logic                       shaped_i,
   output logic signed [QTR_LOG2+1:0] wave_o
);
   localparam int unsigned       AMP   = 1 << QTR_LOG2;
   localparam int unsigned       MAG_W = QTR_LOG2 + 1;
   localparam logic [MAG_W-1:0]  AMP_V = MAG_W'(AMP);

   logic [MAG_W-1:0] lut [AMP];

   // quarter-period table of the shaped profile, filled at elaboration
   for (genvar k = 0; k < AMP; k++) begin : g_lut
      assign lut[k] = MAG_W'(ssc_pkg::shape_val(k, AMP));
   end

   logic [1:0]           quad;
   logic [1:0]           eff;
   logic [QTR_LOG2-1:0]  idx;
   logic [MAG_W-1:0]     j;
   logic [MAG_W-1:0]     mag;

   always_comb begin
      quad = phase_i[QTR_LOG2+1:QTR_LOG2];
      idx  = phase_i[QTR_LOG2-1:0];
      // down sweep is the same wave advanced one quarter
      eff  = quad + {1'b0, down_i};
      j    = eff[0] ? (AMP_V - {1'b0, idx}) : {1'b0, idx};
      if (j == AMP_V)     mag = AMP_V;
      else if (shaped_i)  mag = lut[j[QTR_LOG2-1:0]];
      else                mag = j;
      wave_o = eff[1] ? -signed'({1'b0, mag}) : signed'({1'b0, mag});
   end
endmodule

// File: rtl/ssc_scale.sv
module ssc_scale #(
   parameter int unsigned FRAC_W   = 24,
   parameter int unsigned DEPTH_W  = 6,
   parameter int unsigned QTR_LOG2 = 5,
   parameter int unsigned SCALE_SH = 25
) (
   input  logic                       en_i,
   input  logic                       down_i,
   input  logic [FRAC_W-1:0]          nom_i,
   input  logic [DEPTH_W-1:0]         depth_i,
   input  logic signed [QTR_LOG2+1:0] wave_i,
   output logic signed [FRAC_W:0]     offset_o
);
   localparam longint unsigned K_VAL =
      ((64'd1 << SCALE_SH) + 64'(ssc_pkg::DEPTH_DEN / 2)) / 64'(ssc_pkg::DEPTH_DEN);
   localparam int unsigned K_W    = $clog2(K_VAL + 1);
   localparam int unsigned PROD_W = FRAC_W + DEPTH_W + K_W;
   localparam int unsigned SPAN_W = PROD_W - SCALE_SH;
   localparam int unsigned W_W    = QTR_LOG2 + 2;
   localparam int unsigned CP_W   = W_W + SPAN_W + 2;
   localparam int unsigned OFF_W  = FRAC_W + 1;
   localparam int unsigned AMP    = 1 << QTR_LOG2;

   initial begin : prm_chk
      if (SPAN_W + 1 > OFF_W) $error("ssc_scale: span does not fit the offset word");
      if (SCALE_SH < 12)      $error("ssc_scale: SCALE_SH too small for the depth unit");
   end

   logic [PROD_W-1:0]       prod;
   logic [SPAN_W-1:0]       span;
   logic signed [CP_W-1:0]  span_x, wv_x, dv_x, cprod, dprod;

   always_comb begin
      prod   = PROD_W'(nom_i) * PROD_W'(depth_i) * PROD_W'(K_VAL);
      span   = SPAN_W'(prod >> SCALE_SH);
      span_x = signed'(CP_W'(span));
      wv_x   = CP_W'(wave_i);
      dv_x   = wv_x - signed'(CP_W'(AMP));
      cprod  = wv_x * span_x;
      dprod  = dv_x * span_x;
      if (!en_i)        offset_o = '0;
      else if (down_i)  offset_o = OFF_W'(dprod >>> (QTR_LOG2 + 1));
      else              offset_o = OFF_W'(cprod >>> QTR_LOG2);
   end
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
   parameter int unsigned FRAC_W    = 24,
   parameter int unsigned DEPTH_W   = 6,
   parameter int unsigned DEPTH_MAX = 40,
   parameter int unsigned QTR_LOG2  = 5,
   parameter int unsigned SCALE_SH  = 25
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   tick_i,
   input  logic                   spread_en_i,
   input  logic                   down_mode_i,
   input  logic                   shaped_i,
   input  logic [DEPTH_W-1:0]     depth_i,
   input  logic [FRAC_W-1:0]      nominal_i,
   output logic signed [FRAC_W:0] offset_o,
   output logic                   cycle_start_o
);
   initial begin : prm_chk
      if (DEPTH_MAX == 0 || DEPTH_MAX >= (1 << DEPTH_W)) $error("ssc_profile_gen: bad DEPTH_MAX");
      if (QTR_LOG2 < 2 || QTR_LOG2 > 8)                   $error("ssc_profile_gen: bad QTR_LOG2");
      if (FRAC_W < 8)                                      $error("ssc_profile_gen: FRAC_W too small");
   end

   logic [QTR_LOG2+1:0]        phase;
   logic                       act_en, act_down, act_shaped;
   logic [DEPTH_W-1:0]         act_depth;
   logic [FRAC_W-1:0]          act_nom;
   logic signed [QTR_LOG2+1:0] wave;

   ssc_phase #(
      .QTR_LOG2 (QTR_LOG2), .FRAC_W (FRAC_W),
      .DEPTH_W  (DEPTH_W),  .DEPTH_MAX (DEPTH_MAX)
   ) u_phase (
      .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick_i),
      .en_i (spread_en_i), .down_i (down_mode_i), .shaped_i (shaped_i),
      .depth_i (depth_i), .nom_i (nominal_i),
      .phase_o (phase), .act_en_o (act_en), .act_down_o (act_down),
      .act_shaped_o (act_shaped), .act_depth_o (act_depth),
      .act_nom_o (act_nom), .start_o (cycle_start_o)
   );

   ssc_wave #(.QTR_LOG2 (QTR_LOG2)) u_wave (
      .phase_i (phase), .down_i (act_down), .shaped_i (act_shaped), .wave_o (wave)
   );

   ssc_scale #(
      .FRAC_W (FRAC_W), .DEPTH_W (DEPTH_W),
      .QTR_LOG2 (QTR_LOG2), .SCALE_SH (SCALE_SH)
   ) u_scale (
      .en_i (act_en), .down_i (act_down), .nom_i (act_nom),
      .depth_i (act_depth), .wave_i (wave), .offset_o (offset_o)
   );
endmodule

// File: rtl/ssc_profile_gen_chk.sv
module ssc_profile_gen_chk #(
   parameter int unsigned FRAC_W   = 24,
   parameter int unsigned DEPTH_W  = 6,
   parameter int unsigned QTR_LOG2 = 5
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   tick_i,
   input logic signed [FRAC_W:0] offset_o,
   input logic                   cycle_start_o,
   input logic [QTR_LOG2+1:0]    phase_i,
   input logic                   act_en_i,
   input logic                   act_down_i,
   input logic [DEPTH_W-1:0]     act_depth_i
);
   AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_en_i |-> offset_o == '0); // R7

   AST_DOWN_NONPOS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_en_i && act_down_i) |-> offset_o <= 0); // R5

   AST_START_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cycle_start_o |-> (offset_o == '0 && phase_i == '0)); // R2

   AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cycle_start_o |=> !cycle_start_o); // R2

   AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(offset_o)); // R9

   AST_COMMIT_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_en_i && !$stable(act_depth_i)) |-> phase_i == '0); // R8
endmodule

bind ssc_profile_gen ssc_profile_gen_chk #(
   .FRAC_W (FRAC_W), .DEPTH_W (DEPTH_W), .QTR_LOG2 (QTR_LOG2)
) u_chk (
   .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick_i),
   .offset_o (offset_o), .cycle_start_o (cycle_start_o),
   .phase_i (phase), .act_en_i (act_en), .act_down_i (act_down),
   .act_depth_i (act_depth)
);

// File: tb/ssc_profile_gen_tb.sv
`timescale 1ns/1ps
module ssc_profile_gen_tb;
   logic               clk_i = 1'b0;
   logic               rst_ni = 1'b0;
   logic               tick_i = 1'b0;
   logic               spread_en_i = 1'b0;
   logic               down_mode_i = 1'b0;
   logic               shaped_i = 1'b0;
   logic [5:0]         depth_i = '0;
   logic [23:0]        nominal_i = '0;
   logic signed [24:0] offset_o;
   logic               cycle_start_o;

   int checks = 0, errors = 0;
   bit done = 0;
   string note_tag = "";
   longint obs_max, obs_min;

   // model state
   int     m_p = 0;
   bit     m_en = 0, m_down = 0, m_sh = 0, m_start = 0, last_tick = 0;
   int     m_dep = 0, m_dep_raw = 0;
   longint m_nom = 0;

   always #2 clk_i = ~clk_i;

   ssc_profile_gen u_dut (.*);

   function automatic longint exp_span(longint nom, int dep);
      int d = (dep > 40) ? 40 : dep;
      return (nom * d * 41943) >>> 25;
   endfunction

   function automatic longint exp_off(int p, bit en, bit dn, bit sh, int dep, longint nom);
      longint span, w, f;
      int q, i, e, j;
      if (!en) return 0;
      span = exp_span(nom, dep);
      q = p / 32; i = p % 32;
      e = dn ? (q + 1) % 4 : q;
      j = (e % 2 == 1) ? 32 - i : i;
      f = sh ? longint'((j * (64 - j)) / 32) : longint'(j);
      w = (e < 2) ? f : -f;
      if (dn) return ((w - 32) * span) >>> 6;
      return (w * span) >>> 5;
   endfunction

   task automatic chk(string tag, longint got, longint exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   task automatic model_step(bit tk);
      m_start = 0;
      if (tk) begin
         if (!m_en || m_p == 127) begin
            m_en = spread_en_i; m_down = down_mode_i; m_sh = shaped_i;
            m_dep_raw = int'(depth_i); m_dep = (m_dep_raw > 40) ? 40 : m_dep_raw;
            m_nom = longint'(nominal_i); m_p = 0; m_start = spread_en_i;
         end else m_p++;
      end
   endtask

   task automatic compare();
      longint e = exp_off(m_p, m_en, m_down, m_sh, m_dep, m_nom);
      string t;
      if (note_tag != "")                   t = note_tag;
      else if (!last_tick)                  t = "R9";
      else if (!m_en)                       t = "R7";
      else if (m_dep_raw == 0 || m_dep_raw > 40) t = "R3";
      else if (m_down)                      t = m_sh ? "R5 R6" : "R5";
      else                                  t = m_sh ? "R4 R6" : "R4";
      chk(t, offset_o, e);
      chk("R2", cycle_start_o, m_start);
      if (offset_o > obs_max) obs_max = offset_o;
      if (offset_o < obs_min) obs_min = offset_o;
   endtask

   // inputs are set at a falling edge before this call
   task automatic cyc(bit tk);
      tick_i = tk;
      model_step(tk);
      last_tick = tk;
      @(posedge clk_i);
      @(negedge clk_i);
      compare();
   endtask

   task automatic run(int n, int prob);
      for (int k = 0; k < n; k++) cyc(($urandom % 100) < prob);
   endtask

   task automatic go_idle();
      spread_en_i = 0;
      for (int k = 0; k < 140 && m_en; k++) cyc(1);
   endtask

   task automatic sweep(bit dn, bit sh, int dep, longint nom, string tag);
      longint sp;
      go_idle();
      down_mode_i = dn; shaped_i = sh; depth_i = 6'(dep); nominal_i = 24'(nom);
      spread_en_i = 1;
      cyc(1);
      chk("R2", cycle_start_o, 1);
      obs_max = 0; obs_min = 0;
      for (int k = 0; k < 128; k++) cyc(1);
      chk("R2", cycle_start_o, 1);
      sp = exp_span(nom, dep);
      chk(tag, obs_max, dn ? 0 : sp);
      chk(tag, obs_min, -sp);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      rst_ni = 1;
      chk("R1", offset_o, 0);
      chk("R1", cycle_start_o, 0);
      spread_en_i = 1; depth_i = 6'd20; nominal_i = 24'h400000;
      cyc(0); cyc(0);
      chk("R1", offset_o, 0);

      // full-period peaks per mode and profile
      sweep(0, 0, 8,  64'h800000, "R4");
      sweep(0, 1, 8,  64'h800000, "R4 R6");
      sweep(1, 0, 40, 64'hFFFFFF, "R5");
      sweep(1, 1, 17, 64'h123456, "R5 R6");
      sweep(0, 0, 50, 64'hA00000, "R3");
      sweep(1, 1, 0,  64'hA00000, "R3");

      // deferred take-up mid-period
      sweep(0, 0, 8, 64'h800000, "R4");
      run(10, 100);
      note_tag = "R8";
      depth_i = 6'd30; down_mode_i = 1;
      run(60, 100);
      spread_en_i = 0;
      run(30, 50);
      note_tag = "";
      go_idle();
      note_tag = "R7";
      depth_i = 6'd33; down_mode_i = 0;
      run(20, 60);
      note_tag = "";

      // random settings and tick density
      for (int r = 0; r < 12; r++) begin
         int prob = 30 + (r * 7) % 71;
         spread_en_i = 1; down_mode_i = $urandom % 2; shaped_i = $urandom % 2;
         depth_i = 6'($urandom % 64); nominal_i = 24'($urandom);
         for (int k = 0; k < 500; k++) begin
            if (($urandom % 100) < 4) begin
               case ($urandom % 5)
                  0: spread_en_i = ($urandom % 4) != 0;
                  1: down_mode_i = ~down_mode_i;
                  2: shaped_i    = ~shaped_i;
                  3: depth_i     = 6'($urandom % 64);
                  default: nominal_i = 24'($urandom);
               endcase
            end
            cyc(($urandom % 100) < prob);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk_i);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R2 watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule